// File: doc/BRIEF.md
# Waveform Compare Timer Channel

This block is one counter channel that produces two output levels, A and B, from a 16-bit counter. The counter steps on edges of a slow clock level. That level arrives already selected and divided by logic outside the block. The counter can run freely upward, bounce between zero and a top value, or restart from a compare register C. Three compare registers (A, B and C) raise compare events when the counter steps onto their value. An external event input and a software trigger raise events as well.

Each output holds a two-bit action for each of its four event sources. When several events land in one cycle, a fixed priority decides which single action is applied.

Software controls the channel with one-cycle command pulses (clock on, clock off, trigger) and a 28-bit mode word. It observes the channel through a status word with sticky event flags and a maskable interrupt line. An RC compare can stop the counter until the next trigger, or switch its clock off until the next enable command.

Top module: `wave_timer_chan`

## Requirements
- R1: After reset the counter is 0, both outputs are low, all status flags and mask bits are 0, and the clock is off (status bit 16 low).
- R2: A pulse on `cmd_en` turns the clock on and a pulse on `cmd_dis` turns it off, with off winning when both arrive together. The counter moves only while the clock is on and not stopped. Status bit 16 shows that the counter is running.
- R3: The counter takes one step per rising edge of `clk_src`, or per falling edge when mode bit 9 is set. Mode bits [11:10] gate counting: 0 means no gate, and 1, 2 or 3 allow steps only while `xc_in[0]`, `[1]` or `[2]` is high.
- R4: With mode bits [1:0] = 0 the counter counts up and wraps from 0xFFFF to 0.
- R5: With mode bits [1:0] = 2 the counter counts up, and a step taken at the value of RC returns it to 0.
- R6: With mode bits [1:0] = 1 the counter runs 0 up to 0xFFFF and back down to 0, repeating. With mode bits [1:0] = 3 it does the same with RC as the top value.
- R7: A compare event for RA, RB or RC occurs on a counting step whose new counter value equals that register. Steps caused by a trigger raise no compare event.
- R8: Each action field is two bits: 0 leaves the output unchanged, 1 sets it, 2 clears it and 3 toggles it. The fields for output A are RA compare [13:12], RC compare [15:14], external event [17:16] and software trigger [19:18]. The fields for output B are RB compare [21:20], RC compare [23:22], external event [25:24] and software trigger [27:26].
- R9: At most one action is applied to an output per cycle. It is the action of the highest-priority event that is present, in the order software trigger, external event, RC compare, RA/RB compare, even when that action is 0.
- R10: If mode bit 2 is set, an RC compare stops the counter until the next trigger. If mode bit 3 is set, an RC compare turns the clock off until the next `cmd_en`.
- R11: The external event source is picked by mode bits [7:6] (0 `pin_b_in`, 1 to 3 `xc_in[0]` to `[2]`). Its edge is picked by bits [5:4] (0 none, 1 rising, 2 falling, 3 both). Each detected event sets status bit 7. If mode bit 8 is set, the event also acts as a trigger.
- R12: A trigger (a `cmd_sw` pulse or a triggering external event) sets the counter to 0 on the next cycle, sets the direction to up, and releases a stop.
- R13: The sticky status flags are: bit 0 set by a step taken from 0xFFFF, bits 2, 3 and 4 set by the RA, RB and RC compares, and bit 7 set by the external event. All are cleared by `stat_rd` unless a new event arrives in the same cycle. Bits 17 and 18 mirror outputs A and B.
- R14: Ones on `ie_set` set mask bits and ones on `ie_clr` clear them, with clear winning. Only flag positions 0, 2, 3, 4 and 7 can be masked on. `irq` is high while any flag is set together with its mask bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 28 | Mode word (layout in requirements) |
| ra_val | input | 16 | Compare register A |
| rb_val | input | 16 | Compare register B |
| rc_val | input | 16 | Compare register C |
| cmd_en | input | 1 | Clock-on command pulse |
| cmd_dis | input | 1 | Clock-off command pulse |
| cmd_sw | input | 1 | Software trigger pulse |
| clk_src | input | 1 | Selected counting clock level |
| xc_in | input | 3 | Auxiliary clock levels used for gating and events |
| pin_b_in | input | 1 | Level seen on pin B, usable as event source |
| stat_rd | input | 1 | Status read strobe, clears sticky flags |
| ie_set | input | 8 | Mask bits to set |
| ie_clr | input | 8 | Mask bits to clear |
| cnt_val | output | 16 | Counter value |
| out_a | output | 1 | Output A level |
| out_b | output | 1 | Output B level |
| status | output | 19 | Flags [7:0], running [16], A [17], B [18] |
| imask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
A wrong counter value or direction shows on `cnt_val` one cycle after the step that produced it. In the up-down modes it also shifts every later compare event, so the output levels drift within a few ticks. A wrong stop or clock-off state shows at once on status bit 16, and as a counter that does or does not hold on the next tick. A wrong choice of action under coincident events leaves `out_a` or `out_b` at the wrong level from the next cycle on. A flag that fails to stick or fails to clear shows on `status` and `irq` in the cycle after the event or the read.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TGL  = 2'd3
    } act_e;

    typedef enum logic [1:0] {
        WV_UP      = 2'd0,
        WV_UPDN    = 2'd1,
        WV_UP_RC   = 2'd2,
        WV_UPDN_RC = 2'd3
    } wave_e;

    // Mode word, most significant field first (bit 27 down to bit 0).
    typedef struct packed {
        act_e        b_sw;
        act_e        b_ev;
        act_e        b_rc;
        act_e        b_cmp;
        act_e        a_sw;
        act_e        a_ev;
        act_e        a_rc;
        act_e        a_cmp;
        logic [1:0]  gate_sel;
        logic        clk_inv;
        logic        ev_trig;
        logic [1:0]  ev_src;
        logic [1:0]  ev_edge;
        logic        dis_on_rc;
        logic        stop_on_rc;
        wave_e       wave;
    } mode_t;

    localparam int FLAG_W   = 8;
    localparam int F_OVF    = 0;
    localparam int F_CPA    = 2;
    localparam int F_CPB    = 3;
    localparam int F_CPC    = 4;
    localparam int F_EXT    = 7;
    localparam logic [FLAG_W-1:0] FLAG_IMPL =
        FLAG_W'((1 << F_OVF) | (1 << F_CPA) | (1 << F_CPB) | (1 << F_CPC) | (1 << F_EXT));
    localparam int STAT_W   = 19;
    localparam int S_RUN    = 16;

endpackage

// File: rtl/wtc_edge.sv
module wtc_edge (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level,
    input  logic [1:0] sel,
    output logic       pulse
);
    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d.prev = level;
        unique case (sel)
            2'd1:    pulse = level & ~s_q.prev;
            2'd2:    pulse = ~level & s_q.prev;
            2'd3:    pulse = level ^ s_q.prev;
            default: pulse = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wtc_counter.sv
module wtc_counter
    import wtc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    input  wave_e        wave,
    input  logic [W-1:0] ra,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] rc,
    output logic [W-1:0] cnt,
    output logic         hit_a,
    output logic         hit_b,
    output logic         hit_c,
    output logic         wrap
);
    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         down;
    } cnt_st_t;

    cnt_st_t      s_d, s_q;
    logic [W-1:0] nxt;
    logic [W-1:0] top;
    logic         moving;

    always_comb begin
        s_d    = s_q;
        nxt    = s_q.cnt;
        top    = (wave == WV_UPDN_RC) ? rc : MAXV;
        moving = step & ~clear;
        if (clear) begin
            s_d = '0;
        end else if (step) begin
            unique case (wave)
                WV_UP:    nxt = s_q.cnt + ONE;
                WV_UP_RC: nxt = (s_q.cnt == rc) ? '0 : s_q.cnt + ONE;
                default: begin
                    if (!s_q.down && s_q.cnt < top) begin
                        nxt      = s_q.cnt + ONE;
                        s_d.down = (nxt == top);
                    end else if (s_q.cnt == '0) begin
                        nxt      = (top == '0) ? '0 : ONE;
                        s_d.down = (top != '0) && (nxt == top);
                    end else begin
                        nxt      = s_q.cnt - ONE;
                        s_d.down = (nxt != '0);
                    end
                end
            endcase
            s_d.cnt = nxt;
        end
        hit_a = moving & (nxt == ra);
        hit_b = moving & (nxt == rb);
        hit_c = moving & (nxt == rc);
        wrap  = moving & (s_q.cnt == MAXV);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;

    // R4
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && wave == WV_UP) |=> (s_q.cnt == $past(s_q.cnt) + ONE));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !clear) |=> $stable(s_q.cnt));

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (s_q.cnt == '0 && !s_q.down));
endmodule

// File: rtl/wtc_action.sv
module wtc_action
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_sw,
    input  logic ev_ext,
    input  logic ev_rc,
    input  logic ev_cmp,
    input  act_e act_sw,
    input  act_e act_ext,
    input  act_e act_rc,
    input  act_e act_cmp,
    output logic lvl
);
    typedef struct packed {
        logic lvl;
    } act_st_t;

    act_st_t s_d, s_q;
    act_e    pick;

    always_comb begin
        s_d = s_q;
        if (ev_sw)       pick = act_sw;
        else if (ev_ext) pick = act_ext;
        else if (ev_rc)  pick = act_rc;
        else if (ev_cmp) pick = act_cmp;
        else             pick = ACT_NONE;
        unique case (pick)
            ACT_SET: s_d.lvl = 1'b1;
            ACT_CLR: s_d.lvl = 1'b0;
            ACT_TGL: s_d.lvl = ~s_q.lvl;
            default: s_d.lvl = s_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.lvl;

    // R9
    sw_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sw && act_sw == ACT_SET) |=> s_q.lvl);

    // R9
    sw_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sw && act_sw == ACT_NONE) |=> $stable(s_q.lvl));

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_sw || ev_ext || ev_rc || ev_cmp) |=> $stable(s_q.lvl));
endmodule

// File: rtl/wave_timer_chan.sv
module wave_timer_chan
    import wtc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [27:0]       mode_cfg,
    input  logic [CNT_W-1:0]  ra_val,
    input  logic [CNT_W-1:0]  rb_val,
    input  logic [CNT_W-1:0]  rc_val,
    input  logic              cmd_en,
    input  logic              cmd_dis,
    input  logic              cmd_sw,
    input  logic              clk_src,
    input  logic [2:0]        xc_in,
    input  logic              pin_b_in,
    input  logic              stat_rd,
    input  logic [7:0]        ie_set,
    input  logic [7:0]        ie_clr,
    output logic [CNT_W-1:0]  cnt_val,
    output logic              out_a,
    output logic              out_b,
    output logic [18:0]       status,
    output logic [7:0]        imask,
    output logic              irq
);
    localparam int NOUT = 2;

    typedef struct packed {
        logic              clk_on;
        logic              stopped;
        logic [FLAG_W-1:0] flags;
        logic [FLAG_W-1:0] mask;
    } ctl_t;

    mode_t             mode;
    ctl_t              c_d, c_q;
    logic              tick, ev_pulse, ev_level, gate_ok, step, trig;
    logic              hit_a, hit_b, hit_c, wrap;
    logic [FLAG_W-1:0] new_ev;
    logic              cmp_hit [NOUT];
    logic              lvl     [NOUT];
    act_e              sw_act  [NOUT];
    act_e              ev_act  [NOUT];
    act_e              rc_act  [NOUT];
    act_e              cmp_act [NOUT];

    assign mode = mode_t'(mode_cfg);

    always_comb begin
        unique case (mode.ev_src)
            2'd0:    ev_level = pin_b_in;
            2'd1:    ev_level = xc_in[0];
            2'd2:    ev_level = xc_in[1];
            default: ev_level = xc_in[2];
        endcase
        unique case (mode.gate_sel)
            2'd0:    gate_ok = 1'b1;
            2'd1:    gate_ok = xc_in[0];
            2'd2:    gate_ok = xc_in[1];
            default: gate_ok = xc_in[2];
        endcase
    end

    wtc_edge u_clk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (clk_src),
        .sel   (mode.clk_inv ? 2'd2 : 2'd1),
        .pulse (tick)
    );

    wtc_edge u_ev_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ev_level),
        .sel   (mode.ev_edge),
        .pulse (ev_pulse)
    );

    assign trig = cmd_sw | (ev_pulse & mode.ev_trig);
    assign step = tick & gate_ok & c_q.clk_on & ~c_q.stopped;

    wtc_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .clear (trig),
        .wave  (mode.wave),
        .ra    (ra_val),
        .rb    (rb_val),
        .rc    (rc_val),
        .cnt   (cnt_val),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .hit_c (hit_c),
        .wrap  (wrap)
    );

    assign cmp_hit[0] = hit_a;
    assign cmp_hit[1] = hit_b;
    assign sw_act[0]  = mode.a_sw;
    assign sw_act[1]  = mode.b_sw;
    assign ev_act[0]  = mode.a_ev;
    assign ev_act[1]  = mode.b_ev;
    assign rc_act[0]  = mode.a_rc;
    assign rc_act[1]  = mode.b_rc;
    assign cmp_act[0] = mode.a_cmp;
    assign cmp_act[1] = mode.b_cmp;

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        wtc_action u_act (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_sw   (cmd_sw),
            .ev_ext  (ev_pulse),
            .ev_rc   (hit_c),
            .ev_cmp  (cmp_hit[g]),
            .act_sw  (sw_act[g]),
            .act_ext (ev_act[g]),
            .act_rc  (rc_act[g]),
            .act_cmp (cmp_act[g]),
            .lvl     (lvl[g])
        );
    end

    always_comb begin
        c_d            = c_q;
        new_ev         = '0;
        new_ev[F_OVF]  = wrap;
        new_ev[F_CPA]  = hit_a;
        new_ev[F_CPB]  = hit_b;
        new_ev[F_CPC]  = hit_c;
        new_ev[F_EXT]  = ev_pulse;
        if (cmd_dis)                          c_d.clk_on = 1'b0;
        else if (cmd_en)                      c_d.clk_on = 1'b1;
        else if (hit_c && mode.dis_on_rc)     c_d.clk_on = 1'b0;
        if (trig)                             c_d.stopped = 1'b0;
        else if (hit_c && mode.stop_on_rc)    c_d.stopped = 1'b1;
        c_d.flags = (stat_rd ? '0 : c_q.flags) | new_ev;
        c_d.mask  = (c_q.mask | ie_set) & ~ie_clr & FLAG_IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign out_a  = lvl[0];
    assign out_b  = lvl[1];
    assign imask  = c_q.mask;
    assign irq    = |(c_q.flags & c_q.mask);
    assign status = {lvl[1], lvl[0], c_q.clk_on & ~c_q.stopped, 8'h00, c_q.flags};

    // R2
    dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_dis |=> !status[S_RUN]);

    // R13
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && new_ev == '0) |=> (status[7:0] == '0));

    // R14
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_clr != '0) |=> ((imask & $past(ie_clr)) == '0));

    // R10
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.stopped && !trig) |=> $stable(cnt_val));
endmodule

// File: tb/wave_timer_chan_test.sv
`timescale 1ns/1ps
module wave_timer_chan_test;
    import wtc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    mode_t       mode = '0;
    logic [15:0] ra_val = '0, rb_val = '0, rc_val = '0;
    logic        cmd_en = 1'b0, cmd_dis = 1'b0, cmd_sw = 1'b0;
    logic        clk_src = 1'b0;
    logic [2:0]  xc_in = '0;
    logic        pin_b_in = 1'b0;
    logic        stat_rd = 1'b0;
    logic [7:0]  ie_set = '0, ie_clr = '0;
    logic [15:0] cnt_val;
    logic        out_a, out_b, irq;
    logic [18:0] status;
    logic [7:0]  imask;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wave_timer_chan uut (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode),
        .ra_val(ra_val), .rb_val(rb_val), .rc_val(rc_val),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_sw(cmd_sw),
        .clk_src(clk_src), .xc_in(xc_in), .pin_b_in(pin_b_in),
        .stat_rd(stat_rd), .ie_set(ie_set), .ie_clr(ie_clr),
        .cnt_val(cnt_val), .out_a(out_a), .out_b(out_b),
        .status(status), .imask(imask), .irq(irq)
    );

    typedef struct packed {
        logic [1:0]  wave;
        logic [1:0]  a_cmp, a_rc, b_cmp, b_rc;
        logic [15:0] ra, rb, rc;
        logic [7:0]  ticks;
        logic [15:0] exp_cnt;
        logic        exp_a, exp_b;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd1, 2'd0, 2'd3, 2'd0, 16'd3, 16'd5, 16'd100, 8'd4, 16'd4, 1'b1, 1'b0},
        '{2'd0, 2'd3, 2'd2, 2'd1, 2'd0, 16'd2, 16'd2, 16'd6,   8'd7, 16'd7, 1'b0, 1'b1},
        '{2'd2, 2'd3, 2'd0, 2'd0, 2'd3, 16'd1, 16'd9, 16'd4,   8'd7, 16'd2, 1'b0, 1'b1},
        '{2'd3, 2'd0, 2'd1, 2'd3, 2'd0, 16'd9, 16'd2, 16'd3,   8'd5, 16'd1, 1'b1, 1'b0},
        '{2'd3, 2'd1, 2'd0, 2'd0, 2'd3, 16'd0, 16'd9, 16'd2,   8'd6, 16'd2, 1'b1, 1'b0},
        '{2'd2, 2'd0, 2'd1, 2'd0, 2'd3, 16'd9, 16'd9, 16'd0,   8'd3, 16'd0, 1'b1, 1'b1},
        '{2'd0, 2'd2, 2'd0, 2'd1, 2'd0, 16'd1, 16'd1, 16'd50,  8'd1, 16'd1, 1'b0, 1'b1},
        '{2'd0, 2'd1, 2'd2, 2'd1, 2'd2, 16'd2, 16'd2, 16'd2,   8'd2, 16'd2, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mode = '0; ra_val = '0; rb_val = '0; rc_val = '0;
        cmd_en = 0; cmd_dis = 0; cmd_sw = 0; clk_src = 0; xc_in = '0;
        pin_b_in = 0; stat_rd = 0; ie_set = '0; ie_clr = '0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic tick();
        clk_src = ~mode.clk_inv; cyc();
        clk_src = mode.clk_inv;  cyc();
    endtask

    task automatic pulse_en();  cmd_en = 1;  cyc(); cmd_en = 0;  endtask
    task automatic pulse_sw();  cmd_sw = 1;  cyc(); cmd_sw = 0;  endtask

    function automatic string wave_tag(input logic [1:0] w);
        case (w)
            2'd0:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 cnt", 32'(cnt_val), 0);
        chk("R1 outputs", {out_b, out_a}, 0);
        chk("R1 status", 32'(status), 0);
        chk("R1 mask/irq", {imask, irq}, 0);

        // Vector table: modes, compares, actions
        for (int i = 0; i < NV; i++) begin
            do_reset();
            mode.wave  = wave_e'(VECS[i].wave);
            mode.a_cmp = act_e'(VECS[i].a_cmp);
            mode.a_rc  = act_e'(VECS[i].a_rc);
            mode.b_cmp = act_e'(VECS[i].b_cmp);
            mode.b_rc  = act_e'(VECS[i].b_rc);
            ra_val = VECS[i].ra; rb_val = VECS[i].rb; rc_val = VECS[i].rc;
            pulse_en();
            for (int t = 0; t < int'(VECS[i].ticks); t++) tick();
            chk(wave_tag(VECS[i].wave), 32'(cnt_val), 32'(VECS[i].exp_cnt));
            chk("R7 R8 R9 out_a", 32'(out_a), 32'(VECS[i].exp_a));
            chk("R7 R8 R9 out_b", 32'(out_b), 32'(VECS[i].exp_b));
        end

        // R2 enable / disable
        do_reset();
        tick(); tick(); tick();
        chk("R2 no count while off", 32'(cnt_val), 0);
        pulse_en();
        chk("R2 running bit", 32'(status[16]), 1);
        tick(); tick();
        chk("R2 count while on", 32'(cnt_val), 2);
        cmd_en = 1; cmd_dis = 1; cyc(); cmd_en = 0; cmd_dis = 0;
        chk("R2 disable wins", 32'(status[16]), 0);
        tick();
        chk("R2 hold after off", 32'(cnt_val), 2);

        // R3 gating
        do_reset();
        mode.gate_sel = 2'd1;
        pulse_en();
        tick();
        chk("R3 gated low", 32'(cnt_val), 0);
        xc_in[0] = 1'b1;
        tick();
        chk("R3 gated high", 32'(cnt_val), 1);

        // R3 inverted clock
        do_reset();
        mode.clk_inv = 1'b1;
        clk_src = 1'b1;
        pulse_en();
        cyc(); cyc(); cyc();
        chk("R3 invert no rising count", 32'(cnt_val), 0);
        clk_src = 1'b0; cyc();
        chk("R3 invert falling count", 32'(cnt_val), 1);

        // R10 / R12 stop on RC, trigger restart
        do_reset();
        mode.stop_on_rc = 1'b1; rc_val = 16'd3;
        pulse_en();
        for (int t = 0; t < 5; t++) tick();
        chk("R10 stop at RC", 32'(cnt_val), 3);
        chk("R10 stopped bit", 32'(status[16]), 0);
        pulse_sw();
        chk("R12 trigger zeroes", 32'(cnt_val), 0);
        chk("R12 trigger releases stop", 32'(status[16]), 1);
        tick();
        chk("R12 counts after restart", 32'(cnt_val), 1);

        // R10 disable on RC
        do_reset();
        mode.dis_on_rc = 1'b1; rc_val = 16'd2;
        pulse_en();
        for (int t = 0; t < 4; t++) tick();
        chk("R10 disable at RC", 32'(cnt_val), 2);
        pulse_sw();
        chk("R10 trigger keeps clock off", {16'(cnt_val), 15'd0, status[16]}, 0);
        tick();
        chk("R10 no count after disable", 32'(cnt_val), 0);
        pulse_en(); tick();
        chk("R10 count after enable", 32'(cnt_val), 1);

        // R11 external event as trigger
        do_reset();
        mode.ev_src = 2'd2; mode.ev_edge = 2'd1; mode.ev_trig = 1'b1;
        mode.a_ev = ACT_TGL; mode.b_ev = ACT_SET;
        pulse_en();
        tick(); tick(); tick();
        xc_in[1] = 1'b1; cyc();
        chk("R11 event trigger zeroes", 32'(cnt_val), 0);
        chk("R11 event actions", {out_b, out_a}, 2'b11);
        chk("R11 event flag", 32'(status[7]), 1);
        xc_in[1] = 1'b0; cyc();
        chk("R11 falling ignored", 32'(out_a), 1);
        mode.ev_edge = 2'd3;
        xc_in[1] = 1'b1; cyc();
        xc_in[1] = 1'b0; cyc();
        chk("R11 both edges toggle twice", 32'(out_a), 1);

        // R9 priorities: event over RC, software over event
        do_reset();
        mode.ev_src = 2'd1; mode.ev_edge = 2'd1;
        mode.a_ev = ACT_SET; mode.a_rc = ACT_CLR; rc_val = 16'd2;
        pulse_en();
        tick();
        clk_src = 1'b1; xc_in[0] = 1'b1; cyc();
        clk_src = 1'b0; cyc();
        chk("R9 event beats RC cnt", 32'(cnt_val), 2);
        chk("R9 event beats RC", 32'(out_a), 1);
        xc_in[0] = 1'b0; cyc();
        mode.a_sw = ACT_CLR;
        xc_in[0] = 1'b1; cmd_sw = 1'b1; cyc(); cmd_sw = 1'b0;
        chk("R9 software beats event", 32'(out_a), 0);
        chk("R12 software trigger zeroes", 32'(cnt_val), 0);

        // R13 / R14 flags, mask and irq
        do_reset();
        rc_val = 16'd1;
        ie_set = 8'h10; cyc(); ie_set = '0;
        chk("R14 mask set", 32'(imask), 32'h10);
        pulse_en(); tick();
        chk("R13 RC flag", 32'(status[4]), 1);
        chk("R14 irq", 32'(irq), 1);
        tick();
        chk("R13 sticky", 32'(status[4]), 1);
        stat_rd = 1'b1; cyc(); stat_rd = 1'b0;
        chk("R13 read clears", {24'd0, status[7:0]}, 0);
        chk("R14 irq drops", 32'(irq), 0);
        ie_set = 8'h01; ie_clr = 8'h10; cyc(); ie_set = '0; ie_clr = '0;
        chk("R14 set and clear", 32'(imask), 32'h01);
        ie_set = 8'hFF; cyc(); ie_set = '0;
        chk("R14 unimplemented bits", 32'(imask), 32'h9D);

        // R4 / R13 overflow from all-ones
        do_reset();
        ie_set = 8'h01; cyc(); ie_set = '0;
        pulse_en();
        for (int t = 0; t < 65535; t++) tick();
        chk("R4 reaches all ones", 32'(cnt_val), 32'hFFFF);
        chk("R13 no overflow yet", 32'(status[0]), 0);
        tick();
        chk("R4 wraps", 32'(cnt_val), 0);
        chk("R13 overflow flag", 32'(status[0]), 1);
        chk("R14 overflow irq", 32'(irq), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule